// File: doc/BRIEF.md
# Masked Ternary Word Comparator

The block checks one data word against a comparand word, one bit position at a time, with a per-bit mask that turns a position into a don't-care. A position whose mask bit is one always counts as a hit. A position whose mask bit is zero is a hit only when its data bit and comparand bit are equal. The word is a hit only when every position is a hit.

The per-position hits are reduced by a ripple chain. The chain starts from a constant one. Each stage passes on the value it receives when its position is a hit and drives zero when it is not, and the last stage gives the word result. That result and an input qualifier are captured in one register stage, so the answer appears on the clock edge after the operands are applied. A typical use is a single-entry ternary lookup inside a packet classifier.

Top module: `tern_cmp_top`

## Requirements
- R1: With `rst` high at a rising clock edge, `hit_o` and `vld_o` are both 0 after that edge.
- R2: `vld_o` after a rising edge equals `vld_i` sampled at that edge. The delay is exactly one clock.
- R3: A position whose mask bit is 1 counts as a hit whatever its data and comparand bits are.
- R4: A position whose mask bit is 0 counts as a hit only when its data bit equals its comparand bit.
- R5: `hit_o` after an edge is 1 only if every one of the WIDTH positions sampled at that edge is a hit. One failing position, including position 0 or position WIDTH-1, forces it to 0.
- R6: With all mask bits set to 1, `hit_o` is 1 for any data and comparand.
- R7: `hit_o` is registered on every edge outside reset, whatever `vld_i` is. The answer for operands sampled at an edge is visible right after that edge, with no further pipeline delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operands are valid |
| data_i | input | WIDTH (32) | Word under test |
| cmp_i | input | WIDTH (32) | Comparand word |
| care_n_i | input | WIDTH (32) | Per-bit mask; 1 means don't care |
| hit_o | output | 1 | Registered word match |
| vld_o | output | 1 | Registered copy of vld_i |

## Verification
A stage of the chain that drops its failing position, or that corrupts the value it passes on, shows up as a wrong `hit_o` on the very next edge. That happens for any operand set whose only mismatch lies at that position, so the bench walks a single mismatch across every position, both masked and unmasked. A wrong seed or a missing register shows up the same way, either as a constant result or as a result one cycle off. The bench compares against its own model on every clock, so such an error is caught one edge after the first operands that expose it.

// File: rtl/tern_cmp_pkg.sv
package tern_cmp_pkg;

    localparam int unsigned TC_WIDTH = 32;

    typedef struct packed {
        logic data;
        logic cmp;
        logic care_n;
    } bit_op_t;

    typedef struct packed {
        logic hit;
        logic vld;
    } cmp_res_t;

    function automatic logic bit_hit(input bit_op_t op);
        return op.care_n | ~(op.data ^ op.cmp);
    endfunction

endpackage

// File: rtl/tern_cmp_stage.sv
module tern_cmp_stage
    import tern_cmp_pkg::*;
(
    input  bit_op_t op_i,
    input  logic    chain_i,
    output logic    chain_o
);
    logic pos_ok;

    always_comb begin
        pos_ok  = bit_hit(op_i);
        chain_o = pos_ok ? chain_i : 1'b0;
    end
endmodule

// File: rtl/tern_cmp_chain.sv
module tern_cmp_chain
    import tern_cmp_pkg::*;
#(
    parameter int unsigned WIDTH = TC_WIDTH
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] cmp_i,
    input  logic [WIDTH-1:0] care_n_i,
    output logic             match_o
);
    localparam int unsigned NODES = WIDTH + 1;

    logic [NODES-1:0] link;

    assign link[0] = 1'b1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        bit_op_t op;
        assign op.data   = data_i[g];
        assign op.cmp    = cmp_i[g];
        assign op.care_n = care_n_i[g];

        tern_cmp_stage u_stage (
            .op_i    (op),
            .chain_i (link[g]),
            .chain_o (link[g+1])
        );
    end

    assign match_o = link[NODES-1];
endmodule

// File: rtl/tern_cmp_top.sv
module tern_cmp_top
    import tern_cmp_pkg::*;
#(
    parameter int unsigned WIDTH = TC_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] cmp_i,
    input  logic [WIDTH-1:0] care_n_i,
    output logic             hit_o,
    output logic             vld_o
);
    logic     comb_match;
    cmp_res_t res_q;

    tern_cmp_chain #(.WIDTH(WIDTH)) u_chain (
        .data_i   (data_i),
        .cmp_i    (cmp_i),
        .care_n_i (care_n_i),
        .match_o  (comb_match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.hit <= comb_match;
            res_q.vld <= vld_i;
        end
    end

    assign hit_o = res_q.hit;
    assign vld_o = res_q.vld;
endmodule

// File: rtl/tern_cmp_chk.sv
module tern_cmp_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             vld_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] cmp_i,
    input logic [WIDTH-1:0] care_n_i,
    input logic             hit_o,
    input logic             vld_o
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!hit_o && !vld_o));

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (vld_o == $past(vld_i)));

    assert_all_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (&care_n_i) |=> hit_o);

    assert_one_miss_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones((data_i ^ cmp_i) & ~care_n_i) == 1) |=> !hit_o);

    assert_exact_R4: assert property (@(posedge clk) disable iff (rst)
        (care_n_i == '0) |=> (hit_o == $past(data_i == cmp_i)));
endmodule

bind tern_cmp_top tern_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .vld_i    (vld_i),
    .data_i   (data_i),
    .cmp_i    (cmp_i),
    .care_n_i (care_n_i),
    .hit_o    (hit_o),
    .vld_o    (vld_o)
);

// File: tb/test_tern_cmp_top.sv
module test_tern_cmp_top;
    localparam int W = 32;
    localparam time CLK_PER = 10ns;

    logic         clk = 0;
    logic         rst = 1;
    logic         vld_i = 0;
    logic [W-1:0] data_i = '0, cmp_i = '0, care_n_i = '0;
    logic         hit_o, vld_o;

    int checks = 0, fails = 0;
    bit exp_hit = 0, exp_vld = 0;

    tern_cmp_top #(.WIDTH(W)) i_tern_cmp_top (
        .clk(clk), .rst(rst), .vld_i(vld_i), .data_i(data_i),
        .cmp_i(cmp_i), .care_n_i(care_n_i), .hit_o(hit_o), .vld_o(vld_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Behavioural model: a word hits when no unmasked position differs.
    function automatic bit model_hit(logic [W-1:0] d, logic [W-1:0] c, logic [W-1:0] m);
        for (int i = 0; i < W; i++)
            if (!m[i] && (d[i] != c[i])) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin exp_hit <= 0; exp_vld <= 0; end
        else begin
            exp_hit <= model_hit(data_i, cmp_i, care_n_i);
            exp_vld <= vld_i;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (hit_o !== exp_hit) begin
            fails++;
            $display("FAIL R5/R7 hit_o: actual=%b expected=%b", hit_o, exp_hit);
        end
        checks++;
        if (vld_o !== exp_vld) begin
            fails++;
            $display("FAIL R2 vld_o: actual=%b expected=%b", vld_o, exp_vld);
        end
    end

    task automatic chk(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(logic v, logic [W-1:0] d, logic [W-1:0] c, logic [W-1:0] m);
        vld_i = v; data_i = d; cmp_i = c; care_n_i = m;
        @(posedge clk); #1;
    endtask

    initial begin
        #(CLK_PER * 50000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        data_i = '1; cmp_i = '1; care_n_i = '1; vld_i = 1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 hit in reset", hit_o, 0);
        chk("R1 vld in reset", vld_o, 0);
        rst = 0;

        apply(1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, '0);
        chk("R4 equal words", hit_o, 1);
        chk("R2 valid follows", vld_o, 1);

        apply(0, 32'h1234_5678, 32'h8765_4321, '1);
        chk("R6 all masked", hit_o, 1);
        chk("R2 valid low", vld_o, 0);
        chk("R7 hit without valid", hit_o, 1);

        apply(1, 32'h0000_0001, 32'h0, '0);
        chk("R5 miss at pos 0", hit_o, 0);
        apply(1, 32'h8000_0000, 32'h0, '0);
        chk("R5 miss at pos W-1", hit_o, 0);
        apply(1, 32'h8000_0001, 32'h0, 32'h8000_0001);
        chk("R3 masked misses", hit_o, 1);

        for (int i = 0; i < W; i++) begin
            apply(1, 32'hA5A5_5A5A ^ (32'h1 << i), 32'hA5A5_5A5A, '0);
            chk("R4 single unmasked miss", hit_o, 0);
            apply(1, 32'hA5A5_5A5A ^ (32'h1 << i), 32'hA5A5_5A5A, 32'h1 << i);
            chk("R3 single masked miss", hit_o, 1);
        end

        for (int k = 0; k < 300; k++)
            apply(1'($urandom), $urandom, $urandom, $urandom | $urandom);

        rst = 1;
        @(posedge clk); #1;
        chk("R1 reset mid-run hit", hit_o, 0);
        chk("R1 reset mid-run vld", vld_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule